// File: doc/BRIEF.md
# Auto-Configuring Host Bus Front End

This block sits between a host processor bus and a two-channel serial controller. It samples the host's asynchronous active-low strobes, the chip select, the channel select, the data/control select, two interrupt-acknowledge inputs and a 16-bit address/data bus on the system clock. It turns each host bus cycle into a single-clock access strobe for the rest of the controller. Each strobe is one of five kinds: configuration write, receive-FIFO pop, transmit-FIFO push, register read or register write. The strobe comes with the target channel and a 6-bit register index.

Reset arms the block. While it is armed, the block watches the address strobe. The first chip-selected write then lands in the bus configuration register at whatever address it carries. That write also fixes two things until the next reset: whether the bus is multiplexed (address strobe activity was seen) and whether the handshake is wait-style or acknowledge-style (the channel-select level at that write). After that, the select lines are captured on the rising edge of the address strobe on a multiplexed bus. On a separate-bus host they are captured on the leading edge of the data, read or write strobe. On a separate bus, the register index is taken from the low bits of the addressed channel's command/address register. A ready output follows every access and is held until the host ends its strobe.

Top module: `hbus_frontend`

## Requirements
- R1: While reset is low and just after it is released, every access strobe, `rdy`, `mode_locked`, `mux_mode`, `ack_mode`, `chan_a`, `reg_idx` and `cfg_data` are 0.
- R2: After reset, the first write with `cs_n` low pulses `cfg_we` and loads `ad` into `cfg_data`, whatever the levels of `dsel` and the address. Until that write, chip-selected reads give no strobe and no `rdy`. After it, `mode_locked` is 1 and no later cycle pulses `cfg_we` again.
- R3: `mux_mode` becomes 1 if `as_n` was sampled low at any clock between reset release and the leading edge of the configuration write, and 0 otherwise. It then holds until reset.
- R4: In multiplexed mode, `cs_n`, `chsel`, `dsel` and `ad[5:0]` are taken as they stand at the rising edge of `as_n`. Later changes of these lines during the data phase have no effect.
- R5: In non-multiplexed mode, `cs_n`, `chsel` and `dsel` are taken at the leading (falling) edge of `ds_n`, `rd_n` or `wr_n`.
- R6: A cycle in which `iack1_n` or `iack2_n` is low at the capture point produces no strobe, even with `cs_n` low.
- R7: `chan_a` reports the captured `chsel`: 1 selects channel A, 0 selects channel B.
- R8: With `dsel` high, a read pulses `rx_pop` and a write pulses `tx_push`.
- R9: With `dsel` low, a read pulses `reg_rd` and a write pulses `reg_wr`. `reg_idx` is the captured `ad[5:0]` in multiplexed mode. In non-multiplexed mode it is `cmdidx_a` for channel A and `cmdidx_b` for channel B.
- R10: `ack_mode` takes the captured `chsel` of the configuration write (1 = acknowledge style, 0 = wait style) and holds it until reset.
- R11: Each bus cycle gives at most one strobe, one clock wide. It is high in the third clock after the clock at which the host's strobe is first sampled low.
- R12: `rdy` rises in the clock after the access strobe. It falls in the third clock after the host's strobe is sampled high again.
- R13: A cycle is a write when `wr_n` is low, or when `ds_n` is low with `rnw` low. It is a read when `rd_n` is low, or when `ds_n` is low with `rnw` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; arms configuration |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low, direction from `rnw` |
| rnw | input | 1 | Direction for `ds_n` cycles: 1 read, 0 write |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| chsel | input | 1 | Channel select: 1 = A, 0 = B |
| dsel | input | 1 | 1 = FIFO data, 0 = internal register |
| iack1_n | input | 1 | Interrupt acknowledge input 1, active low |
| iack2_n | input | 1 | Interrupt acknowledge input 2, active low |
| ad | input | 16 | Address/data bus (input side) |
| cmdidx_a | input | 6 | Low bits of channel A command/address register |
| cmdidx_b | input | 6 | Low bits of channel B command/address register |
| cfg_we | output | 1 | One-clock configuration write strobe |
| cfg_data | output | 16 | Bus configuration register contents |
| rx_pop | output | 1 | One-clock receive-FIFO read strobe |
| tx_push | output | 1 | One-clock transmit-FIFO write strobe |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_wr | output | 1 | One-clock register write strobe |
| chan_a | output | 1 | Channel of the last access, 1 = A |
| reg_idx | output | 6 | Register index of the last access |
| mode_locked | output | 1 | Configuration write has happened |
| mux_mode | output | 1 | Locked bus mode, 1 = multiplexed |
| ack_mode | output | 1 | Locked handshake, 1 = acknowledge style |
| rdy | output | 1 | Ready/acknowledge to the host |

## Verification
The hardest situation to reach is a multiplexed cycle in which the select lines say something different at the address-strobe rising edge than during the data strobe. Only that cycle shows whether capture happens on the right edge. The stimulus creates it on purpose: after each address-strobe rise, the bench inverts chip select, channel select and data/control select and puts data with different low bits on the bus. It also runs a cycle that is deselected at the address edge but selected during the data phase. The bench also takes the block through two reset sessions. One has no address-strobe activity and one has some, so both lock decisions are seen. Each session begins with a chip-selected read that must be ignored while the block is armed.

// File: rtl/hbf_pkg.sv
// Package hbf_pkg
// Shared types for the host bus front end: the decoded access kind and the
// packed view of the synchronized control pins.
package hbf_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_RX_POP,
        ACC_TX_PUSH,
        ACC_REG_RD,
        ACC_REG_WR
    } acc_kind_e;

    // Control pins after synchronization, most significant field first.
    typedef struct packed {
        logic rnw;
        logic iack2_n;
        logic iack1_n;
        logic dsel;
        logic chsel;
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic ds_n;
        logic as_n;
    } ctl_pins_t;

    localparam int CTL_W = $bits(ctl_pins_t);

    // Idle levels: strobes and selects inactive, acknowledges inactive.
    localparam logic [CTL_W-1:0] CTL_IDLE = 10'b0110011111;

endpackage

// File: rtl/hbf_sync.sv
// Module hbf_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own; a multi-bit bus must be held stable
// by the host around the moment it is used.
module hbf_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    // First stage: sample the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Later stages: shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= RST_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/hbf_mode_ctl.sv
// Module hbf_mode_ctl
// Holds the post-reset arming flag, detects address-strobe activity, and on
// the configuration write locks the bus mode and handshake style and stores
// the configuration word. Assumes cfg_hit is a one-clock request from the
// capture stage.
module hbf_mode_ctl #(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_n_s,
    input  logic            cfg_hit,
    input  logic            req_ch,
    input  logic [AD_W-1:0] ad_s,
    output logic            armed,
    output logic            mux_eff,
    output logic            mux_mode,
    output logic            ack_mode,
    output logic [AD_W-1:0] cfg_data
);

    logic seen_as;

    // Bus mode to apply now: locked value once configured, else activity so far.
    always_comb begin
        mux_eff = armed ? (seen_as | ~as_n_s) : mux_mode;
    end

    // Arming, activity tracking and locking of mode and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b1;
            seen_as  <= 1'b0;
            mux_mode <= 1'b0;
            ack_mode <= 1'b0;
            cfg_data <= '0;
        end else if (armed) begin
            if (!as_n_s) seen_as <= 1'b1;
            if (cfg_hit) begin
                armed    <= 1'b0;
                mux_mode <= mux_eff;
                ack_mode <= req_ch;
                cfg_data <= ad_s;
            end
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && $past(!armed)) |-> ($stable(mux_mode) && $stable(ack_mode) && $stable(cfg_data))) // R3
        else $error("bus mode or handshake changed after lock");

endmodule

// File: rtl/hbf_capture.sv
// Module hbf_capture
// Finds strobe edges on the synchronized pins, captures the select lines on
// the edge that the bus mode calls for, and decodes the leading edge of a
// data phase into one access request. Assumes the pins are already
// synchronized and that in multiplexed mode the address strobe rises before
// the data strobe falls.
module hbf_capture
    import hbf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_pins_t        pins,
    input  logic [IDX_W-1:0] ad_lo,
    input  logic [IDX_W-1:0] cmdidx_a,
    input  logic [IDX_W-1:0] cmdidx_b,
    input  logic             mux_eff,
    input  logic             armed,
    output acc_kind_e        kind,
    output logic             req_ch,
    output logic [IDX_W-1:0] req_idx,
    output logic             dstb
);

    logic             prev_as_n;
    logic             prev_dstb;
    logic             lat_cs;
    logic             lat_ch;
    logic             lat_dc;
    logic [IDX_W-1:0] lat_idx;
    logic             lead;
    logic             as_rise;
    logic             cs_ok;
    logic             use_cs;
    logic             use_dc;
    logic             is_wr;

    // Edge detection and qualified chip select from the current pin levels.
    always_comb begin
        dstb    = ~pins.ds_n | ~pins.rd_n | ~pins.wr_n;
        lead    = dstb & ~prev_dstb;
        as_rise = pins.as_n & ~prev_as_n;
        cs_ok   = ~pins.cs_n & pins.iack1_n & pins.iack2_n;
        is_wr   = ~pins.wr_n | (~pins.ds_n & ~pins.rnw);
    end

    // Pick the select source: latched at address strobe, or live at the data edge.
    always_comb begin
        if (mux_eff) begin
            use_cs  = lat_cs;
            req_ch  = lat_ch;
            use_dc  = lat_dc;
            req_idx = lat_idx;
        end else begin
            use_cs  = cs_ok;
            req_ch  = pins.chsel;
            use_dc  = pins.dsel;
            req_idx = pins.chsel ? cmdidx_a : cmdidx_b;
        end
    end

    // Decode the leading edge into one access kind.
    always_comb begin
        kind = ACC_NONE;
        if (lead && use_cs) begin
            if (armed) begin
                if (is_wr) kind = ACC_CFG;
            end else if (use_dc) begin
                kind = is_wr ? ACC_TX_PUSH : ACC_RX_POP;
            end else begin
                kind = is_wr ? ACC_REG_WR : ACC_REG_RD;
            end
        end
    end

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_as_n <= 1'b1;
            prev_dstb <= 1'b0;
        end else begin
            prev_as_n <= pins.as_n;
            prev_dstb <= dstb;
        end
    end

    // Capture select lines and address on the address strobe rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cs  <= 1'b0;
            lat_ch  <= 1'b0;
            lat_dc  <= 1'b0;
            lat_idx <= '0;
        end else if (as_rise && mux_eff) begin
            lat_cs  <= cs_ok;
            lat_ch  <= pins.chsel;
            lat_dc  <= pins.dsel;
            lat_idx <= ad_lo;
        end
    end

    AST_KIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_NONE) |=> (kind == ACC_NONE)) // R11
        else $error("two access requests in consecutive clocks");

    AST_IACK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_eff && (!pins.iack1_n || !pins.iack2_n)) |-> (kind == ACC_NONE)) // R6
        else $error("access decoded during interrupt acknowledge");

endmodule

// File: rtl/hbf_access.sv
// Module hbf_access
// Registers the decoded request into one-clock access strobes together with
// channel and register index, and drives the ready handshake. Assumes kind
// is non-idle for at most one clock per bus cycle.
module hbf_access
    import hbf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic             req_ch,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             dstb,
    output logic             cfg_we,
    output logic             rx_pop,
    output logic             tx_push,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic             chan_a,
    output logic [IDX_W-1:0] reg_idx,
    output logic             rdy
);

    logic any_stb;

    // Any strobe currently asserted.
    always_comb begin
        any_stb = cfg_we | rx_pop | tx_push | reg_rd | reg_wr;
    end

    // One-clock access strobes from the request kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_we  <= 1'b0;
            rx_pop  <= 1'b0;
            tx_push <= 1'b0;
            reg_rd  <= 1'b0;
            reg_wr  <= 1'b0;
        end else begin
            cfg_we  <= (kind == ACC_CFG);
            rx_pop  <= (kind == ACC_RX_POP);
            tx_push <= (kind == ACC_TX_PUSH);
            reg_rd  <= (kind == ACC_REG_RD);
            reg_wr  <= (kind == ACC_REG_WR);
        end
    end

    // Channel and index of the most recent access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_a  <= 1'b0;
            reg_idx <= '0;
        end else if (kind != ACC_NONE) begin
            chan_a  <= req_ch;
            reg_idx <= req_idx;
        end
    end

    // Ready: set after a strobe, cleared once the host strobe goes away.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy <= 1'b0;
        else if (any_stb) rdy <= 1'b1;
        else if (!dstb)   rdy <= 1'b0;
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_we, rx_pop, tx_push, reg_rd, reg_wr})) // R11
        else $error("more than one access strobe");

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb) // R11
        else $error("access strobe longer than one clock");

    AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> rdy) // R12
        else $error("ready missing after strobe");

    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !dstb && !any_stb) |=> !rdy) // R12
        else $error("ready held after host strobe ended");

endmodule

// File: rtl/hbus_frontend.sv
// Module hbus_frontend
// Host bus front end of a two-channel serial controller: synchronizes the
// host pins, detects the bus mode after reset, routes the first write into
// the configuration register and decodes later cycles into access strobes.
// Assumes the host holds ad and the selects stable around their capture edge.
module hbus_frontend
    import hbf_pkg::*;
#(
    parameter int AD_W        = 16,
    parameter int IDX_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic             rnw,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cs_n,
    input  logic             chsel,
    input  logic             dsel,
    input  logic             iack1_n,
    input  logic             iack2_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [IDX_W-1:0] cmdidx_a,
    input  logic [IDX_W-1:0] cmdidx_b,
    output logic             cfg_we,
    output logic [AD_W-1:0]  cfg_data,
    output logic             rx_pop,
    output logic             tx_push,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic             chan_a,
    output logic [IDX_W-1:0] reg_idx,
    output logic             mode_locked,
    output logic             mux_mode,
    output logic             ack_mode,
    output logic             rdy
);

    ctl_pins_t        pins_raw;
    logic [CTL_W-1:0] pins_vec;
    ctl_pins_t        pins_s;
    logic [AD_W-1:0]  ad_s;
    acc_kind_e        kind;
    logic             req_ch;
    logic [IDX_W-1:0] req_idx;
    logic             dstb;
    logic             armed;
    logic             mux_eff;
    logic             cfg_hit;

    // Gather the raw control pins into the packed view.
    always_comb begin
        pins_raw = '{rnw: rnw, iack2_n: iack2_n, iack1_n: iack1_n, dsel: dsel,
                     chsel: chsel, cs_n: cs_n, wr_n: wr_n, rd_n: rd_n,
                     ds_n: ds_n, as_n: as_n};
        pins_s      = ctl_pins_t'(pins_vec);
        cfg_hit     = (kind == ACC_CFG);
        mode_locked = ~armed;
    end

    hbf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_vec)
    );

    hbf_sync #(.W(AD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ad),
        .q     (ad_s)
    );

    hbf_mode_ctl #(.AD_W(AD_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n_s   (pins_s.as_n),
        .cfg_hit  (cfg_hit),
        .req_ch   (req_ch),
        .ad_s     (ad_s),
        .armed    (armed),
        .mux_eff  (mux_eff),
        .mux_mode (mux_mode),
        .ack_mode (ack_mode),
        .cfg_data (cfg_data)
    );

    hbf_capture #(.IDX_W(IDX_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins_s),
        .ad_lo    (ad_s[IDX_W-1:0]),
        .cmdidx_a (cmdidx_a),
        .cmdidx_b (cmdidx_b),
        .mux_eff  (mux_eff),
        .armed    (armed),
        .kind     (kind),
        .req_ch   (req_ch),
        .req_idx  (req_idx),
        .dstb     (dstb)
    );

    hbf_access #(.IDX_W(IDX_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .req_ch  (req_ch),
        .req_idx (req_idx),
        .dstb    (dstb),
        .cfg_we  (cfg_we),
        .rx_pop  (rx_pop),
        .tx_push (tx_push),
        .reg_rd  (reg_rd),
        .reg_wr  (reg_wr),
        .chan_a  (chan_a),
        .reg_idx (reg_idx),
        .rdy     (rdy)
    );

    AST_NO_ACCESS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_locked |-> !(rx_pop || tx_push || reg_rd || reg_wr)) // R2
        else $error("data access before configuration write");

    AST_CFG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked |=> !cfg_we) // R2
        else $error("second configuration write");

endmodule

// File: tb/hbus_frontend_tb.sv
module hbus_frontend_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1, ds_n = 1'b1, rnw = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic        cs_n = 1'b1, chsel = 1'b0, dsel = 1'b0;
    logic        iack1_n = 1'b1, iack2_n = 1'b1;
    logic [15:0] ad = '0;
    logic [5:0]  cmdidx_a = '0, cmdidx_b = '0;
    logic        cfg_we, rx_pop, tx_push, reg_rd, reg_wr, chan_a;
    logic [15:0] cfg_data;
    logic [5:0]  reg_idx;
    logic        mode_locked, mux_mode, ack_mode, rdy;

    int n_vec = 0;
    int n_err = 0;
    int cyc = 0;

    hbus_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rnw(rnw),
        .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n), .chsel(chsel), .dsel(dsel),
        .iack1_n(iack1_n), .iack2_n(iack2_n), .ad(ad),
        .cmdidx_a(cmdidx_a), .cmdidx_b(cmdidx_b),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .rx_pop(rx_pop),
        .tx_push(tx_push), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .chan_a(chan_a), .reg_idx(reg_idx), .mode_locked(mode_locked),
        .mux_mode(mux_mode), .ack_mode(ack_mode), .rdy(rdy)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: pins pass through a two-deep delay queue, then
    // the bus rules are applied to the delayed view.
    logic [25:0] q_pins [$];
    bit m_pa, m_pd, m_lcs, m_lch, m_ldc, m_armed, m_seen, m_mux, m_ack;
    bit m_cfg_we, m_rx, m_tx, m_rd, m_wr, m_ch, m_rdy;
    logic [5:0]  m_lidx, m_idx;
    logic [15:0] m_cfg;
    localparam logic [25:0] IDLE = {10'b0110011111, 16'h0};

    task automatic model_step();
        logic [25:0] s;
        bit s_as, s_ds, s_rd, s_wr, s_cs, s_ch, s_dc, s_i1, s_i2, s_rnw;
        bit dstb, lead, arise, csok, mx, ucs, uch, udc, wr, any, nrdy;
        logic [5:0] uidx;
        int k;
        if (!rst_n) begin
            q_pins = {IDLE, IDLE};
            m_pa = 1; m_pd = 0; m_lcs = 0; m_lch = 0; m_ldc = 0; m_lidx = 0;
            m_armed = 1; m_seen = 0; m_mux = 0; m_ack = 0; m_cfg = 0;
            m_cfg_we = 0; m_rx = 0; m_tx = 0; m_rd = 0; m_wr = 0; m_ch = 0; m_idx = 0; m_rdy = 0;
            return;
        end
        s = q_pins[0];
        {s_rnw, s_i2, s_i1, s_dc, s_ch, s_cs, s_wr, s_rd, s_ds, s_as} = s[25:16];
        dstb  = !s_ds || !s_rd || !s_wr;
        lead  = dstb && !m_pd;
        arise = s_as && !m_pa;
        csok  = !s_cs && s_i1 && s_i2;
        mx    = m_armed ? (m_seen || !s_as) : m_mux;
        wr    = !s_wr || (!s_ds && !s_rnw);
        ucs   = mx ? m_lcs : csok;
        uch   = mx ? m_lch : s_ch;
        udc   = mx ? m_ldc : s_dc;
        uidx  = mx ? m_lidx : (s_ch ? cmdidx_a : cmdidx_b);
        any   = m_cfg_we || m_rx || m_tx || m_rd || m_wr;
        nrdy  = any ? 1'b1 : (!dstb ? 1'b0 : m_rdy);
        k = 0;
        if (lead && ucs) begin
            if (m_armed) k = wr ? 1 : 0;
            else if (udc) k = wr ? 3 : 2;
            else k = wr ? 5 : 4;
        end
        m_cfg_we = (k == 1); m_rx = (k == 2); m_tx = (k == 3); m_rd = (k == 4); m_wr = (k == 5);
        if (k != 0) begin m_ch = uch; m_idx = uidx; end
        m_rdy = nrdy;
        if (m_armed) begin
            if (!s_as) m_seen = 1;
            if (k == 1) begin m_armed = 0; m_mux = mx; m_ack = uch; m_cfg = s[15:0]; end
        end
        if (arise && mx) begin m_lcs = csok; m_lch = s_ch; m_ldc = s_dc; m_lidx = s[5:0]; end
        m_pa = s_as; m_pd = dstb;
        void'(q_pins.pop_front());
        q_pins.push_back({rnw, iack2_n, iack1_n, dsel, chsel, cs_n, wr_n, rd_n, ds_n, as_n, ad});
    endtask

    // Directed-check monitor state.
    int c_cfg, c_rx, c_tx, c_rd, c_wr, c_rdy;
    int t_fall, t_rel, t_pulse, t_rdy_on, t_rdy_off;
    bit last_ch, prev_rdy;
    logic [5:0] last_idx;

    always @(posedge clk) begin
        cyc++;
        model_step();
        #1;
        check("R11", "strobes vs model", {cfg_we, rx_pop, tx_push, reg_rd, reg_wr},
              {m_cfg_we, m_rx, m_tx, m_rd, m_wr});
        check("R12", "rdy vs model", rdy, m_rdy);
        check("R3", "mode vs model", {mode_locked, mux_mode, ack_mode}, {!m_armed, m_mux, m_ack});
        check("R2", "cfg_data vs model", cfg_data, m_cfg);
        check("R9", "chan/idx vs model", {chan_a, reg_idx}, {m_ch, m_idx});
        if (cfg_we) c_cfg++;
        if (rx_pop) c_rx++;
        if (tx_push) c_tx++;
        if (reg_rd) c_rd++;
        if (reg_wr) c_wr++;
        if (cfg_we || rx_pop || tx_push || reg_rd || reg_wr) begin
            t_pulse = cyc; last_ch = chan_a; last_idx = reg_idx;
        end
        if (rdy && !prev_rdy) begin c_rdy++; t_rdy_on = cyc; end
        if (!rdy && prev_rdy) t_rdy_off = cyc;
        prev_rdy = rdy;
    end

    task automatic clr();
        c_cfg = 0; c_rx = 0; c_tx = 0; c_rd = 0; c_wr = 0; c_rdy = 0;
    endtask

    task automatic expect_acc(input string req, input int ncfg, input int nrx, input int ntx,
                              input int nrd, input int nwr, input int ch, input int idx);
        check(req, "strobe counts", {c_cfg[3:0], c_rx[3:0], c_tx[3:0], c_rd[3:0], c_wr[3:0]},
              {ncfg[3:0], nrx[3:0], ntx[3:0], nrd[3:0], nwr[3:0]});
        if (ncfg + nrx + ntx + nrd + nwr > 0) check(req, "channel", last_ch, ch);
        if (nrd + nwr > 0) check(req, "reg index", last_idx, idx);
        check(req, "rdy pulses", c_rdy, ncfg + nrx + ntx + nrd + nwr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; as_n = 1; ds_n = 1; rd_n = 1; wr_n = 1; cs_n = 1;
        iack1_n = 1; iack2_n = 1; ad = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    // Separate-bus cycle: selects set up, then one strobe asserted and held.
    task automatic nm_cyc(input bit wr, input bit via_ds, input bit cs, input bit ch, input bit dc,
                          input logic [15:0] data, input bit i1, input bit i2);
        clr();
        @(negedge clk);
        cs_n = !cs; chsel = ch; dsel = dc; iack1_n = i1; iack2_n = i2; rnw = !wr; ad = data;
        @(negedge clk);
        if (via_ds) ds_n = 0; else if (wr) wr_n = 0; else rd_n = 0;
        t_fall = cyc;
        repeat (8) @(negedge clk);
        ds_n = 1; rd_n = 1; wr_n = 1;
        t_rel = cyc;
        repeat (2) @(negedge clk);
        cs_n = 1; iack1_n = 1; iack2_n = 1;
        repeat (5) @(negedge clk);
    endtask

    // Multiplexed cycle: selects and address on the address-strobe edge, then
    // every select is flipped and data placed before the data phase.
    task automatic mx_cyc(input bit wr, input bit cs, input bit ch, input bit dc,
                          input logic [5:0] addr, input logic [15:0] data, input bit i1);
        clr();
        @(negedge clk);
        cs_n = !cs; chsel = ch; dsel = dc; iack1_n = i1; rnw = !wr; ad = {10'h0, addr};
        as_n = 0;
        repeat (3) @(negedge clk);
        as_n = 1;
        @(negedge clk);
        cs_n = cs; chsel = !ch; dsel = !dc; iack1_n = 1; ad = data;
        repeat (3) @(negedge clk);
        if (wr) wr_n = 0; else rd_n = 0;
        t_fall = cyc;
        repeat (8) @(negedge clk);
        rd_n = 1; wr_n = 1;
        repeat (6) @(negedge clk);
        cs_n = 1; ad = 0;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", {cfg_we, rx_pop, tx_push, reg_rd, reg_wr, rdy,
              mode_locked, mux_mode, ack_mode, chan_a}, 0);
        // Session 1: separate address and data bus.
        do_reset();
        check("R1", "outputs after reset", {cfg_data, reg_idx, rdy, mode_locked, mux_mode, ack_mode}, 0);
        cmdidx_a = 6'h25; cmdidx_b = 6'h03;
        nm_cyc(0, 0, 1, 1, 1, 16'h0, 1, 1);
        expect_acc("R2", 0, 0, 0, 0, 0, 0, 0);
        check("R2", "still armed", mode_locked, 0);
        nm_cyc(1, 0, 1, 0, 1, 16'h1234, 1, 1);
        expect_acc("R2", 1, 0, 0, 0, 0, 0, 0);
        check("R2", "cfg_data", cfg_data, 16'h1234);
        check("R3", "non-mux locked", {mode_locked, mux_mode}, 2'b10);
        check("R10", "wait style", ack_mode, 0);
        check("R11", "strobe latency", t_pulse - t_fall, 3);
        check("R12", "rdy rise", t_rdy_on - t_pulse, 1);
        check("R12", "rdy release", t_rdy_off - t_rel, 3);
        nm_cyc(1, 0, 1, 1, 1, 16'hBEEF, 1, 1);
        expect_acc("R8", 0, 0, 1, 0, 0, 1, 0);
        check("R7", "chan A", chan_a, 1);
        check("R2", "no second cfg", cfg_data, 16'h1234);
        nm_cyc(0, 1, 1, 0, 1, 16'h0, 1, 1);
        expect_acc("R13", 0, 1, 0, 0, 0, 0, 0);
        check("R7", "chan B", chan_a, 0);
        nm_cyc(1, 1, 1, 1, 0, 16'h0, 1, 1);
        expect_acc("R9", 0, 0, 0, 0, 1, 1, 6'h25);
        nm_cyc(0, 0, 1, 0, 0, 16'h0, 1, 1);
        expect_acc("R9", 0, 0, 0, 1, 0, 0, 6'h03);
        check("R5", "live select", {chan_a, reg_idx}, {1'b0, 6'h03});
        nm_cyc(1, 0, 1, 1, 1, 16'h0, 0, 1);
        expect_acc("R6", 0, 0, 0, 0, 0, 0, 0);
        nm_cyc(0, 0, 1, 1, 1, 16'h0, 1, 0);
        expect_acc("R6", 0, 0, 0, 0, 0, 0, 0);
        nm_cyc(1, 0, 0, 1, 1, 16'h0, 1, 1);
        expect_acc("R5", 0, 0, 0, 0, 0, 0, 0);
        // Session 2: multiplexed bus.
        do_reset();
        check("R1", "cleared by reset", {cfg_data, mode_locked, mux_mode, ack_mode}, 0);
        mx_cyc(0, 1, 1, 1, 6'h11, 16'h0, 1);
        expect_acc("R2", 0, 0, 0, 0, 0, 0, 0);
        mx_cyc(1, 1, 1, 0, 6'h3F, 16'hA5C3, 1);
        expect_acc("R2", 1, 0, 0, 0, 0, 1, 0);
        check("R2", "cfg_data mux", cfg_data, 16'hA5C3);
        check("R3", "mux locked", {mode_locked, mux_mode}, 2'b11);
        check("R10", "ack style", ack_mode, 1);
        mx_cyc(0, 1, 1, 1, 6'h00, 16'h0000, 1);
        expect_acc("R4", 0, 1, 0, 0, 0, 1, 0);
        mx_cyc(1, 1, 0, 0, 6'h2A, 16'h0015, 1);
        expect_acc("R4", 0, 0, 0, 0, 1, 0, 6'h2A);
        mx_cyc(1, 0, 1, 1, 6'h01, 16'h0, 1);
        expect_acc("R4", 0, 0, 0, 0, 0, 0, 0);
        mx_cyc(0, 1, 1, 0, 6'h07, 16'h0, 0);
        expect_acc("R6", 0, 0, 0, 0, 0, 0, 0);
        check("R10", "ack held", {mux_mode, ack_mode}, 2'b11);
        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule